// File: doc/BRIEF.md
# User-Level Event Branch Dispatcher

This block turns a performance-monitor alert into a cheap branch to a user-mode handler. The block remembers the alert as a pending request. The request is taken only while the core runs unprivileged code. At the moment it is taken, the dispatcher checks two enable bits in its control/status register. If both are set, it records where execution was heading, marks the event as having happened, disarms itself, and gives the fetch unit a new address for one cycle. The privilege level does not change.

Software programs the control/status, handler-address and return-address registers through a single write port. The handler can then re-arm the dispatcher by setting the global enable bit again. The dispatcher does not decode the return-from-handler instruction, does not count events and handles no other exception class.

Top module: `user_event_branch`

## Requirements
- R1: After reset, req_pending, redirect_valid, redirect_pc, return_addr, status and handler_addr are all zero.
- R2: A one-cycle pulse on pm_req sets req_pending on the next edge. The request is taken in a cycle where req_pending and user_mode are both 1. While user_mode is 0, req_pending stays 1 for any number of cycles.
- R3: Taking a request clears req_pending on the same edge, unless pm_req is also high in that cycle.
- R4: A taken request redirects only if status bit 0 (global enable) and status bit 1 (monitor enable) are both 1. Otherwise the request is consumed, no redirect_valid pulse occurs, and status and return_addr keep their values.
- R5: On a redirect, status bit 0 is cleared, status bit 2 (event occurred) is set, and all other status bits keep their values.
- R6: On a redirect, return_addr receives cur_pc with its two low bits forced to zero.
- R7: redirect_valid is a single-cycle pulse on the edge after the request is taken. While it is high, redirect_pc equals the handler_addr value from the cycle in which the request was taken.
- R8: Values written to the handler and return registers have their two low bits forced to zero.
- R9: In a cycle where a request is taken, software writes to the status register and to the return register are discarded.
- R10: When sw_we is high, sw_sel selects the target register: 0 for status (low 8 bits of sw_wdata), 1 for handler, 2 for return. Outside the collision case of R9, the write takes effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | AW | Address of the next instruction to execute |
| user_mode | input | 1 | Core is in unprivileged state |
| pm_req | input | 1 | Performance-monitor alert pulse |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Write target: 0 status, 1 handler, 2 return |
| sw_wdata | input | AW | Software write data |
| redirect_valid | output | 1 | One-cycle pulse: load redirect_pc into fetch |
| redirect_pc | output | AW | Handler address for fetch |
| return_addr | output | AW | Saved return address |
| status | output | SW | Control/status register |
| handler_addr | output | AW | Handler-address register |
| req_pending | output | 1 | Alert waiting to be taken |

## Verification
The hardest case to reach from the ports is a software write that lands in the same cycle a request is taken. The stimulus gets there by raising the alert one cycle before a write, with user mode already set. The write strobe then falls exactly in the acceptance cycle. A second hard case is a request held through a long stretch of privileged cycles. The bench keeps user_mode low for several cycles, checks that the request is still pending, and only then releases it.

// File: rtl/user_event_branch.sv
module user_event_branch #(
  parameter int AW      = 32,
  parameter int SW      = 8,
  parameter int GE_BIT  = 0,
  parameter int PME_BIT = 1,
  parameter int OCC_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cur_pc,
  input  logic          user_mode,
  input  logic          pm_req,
  input  logic          sw_we,
  input  logic [1:0]    sw_sel,
  input  logic [AW-1:0] sw_wdata,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  output logic [AW-1:0] return_addr,
  output logic [SW-1:0] status,
  output logic [AW-1:0] handler_addr,
  output logic          req_pending
);
  localparam logic [AW-1:0] ALIGN = ~AW'(3);
  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_HND  = 2'd1;
  localparam logic [1:0] SEL_RET  = 2'd2;

  logic accept, fire;
  assign accept = req_pending & user_mode;
  assign fire   = accept & status[GE_BIT] & status[PME_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_pending    <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      return_addr    <= '0;
      status         <= '0;
      handler_addr   <= '0;
    end else begin
      req_pending    <= (req_pending & ~accept) | pm_req;
      redirect_valid <= fire;
      if (fire) redirect_pc <= handler_addr;

      if (fire)
        status <= (status & ~(SW'(1) << GE_BIT)) | (SW'(1) << OCC_BIT);
      else if (sw_we && sw_sel == SEL_STAT && !accept)
        status <= sw_wdata[SW-1:0];

      if (fire)
        return_addr <= cur_pc & ALIGN;
      else if (sw_we && sw_sel == SEL_RET && !accept)
        return_addr <= sw_wdata & ALIGN;

      if (sw_we && sw_sel == SEL_HND)
        handler_addr <= sw_wdata & ALIGN;
    end
  end
endmodule

module user_event_branch_chk #(
  parameter int AW      = 32,
  parameter int SW      = 8,
  parameter int GE_BIT  = 0,
  parameter int PME_BIT = 1,
  parameter int OCC_BIT = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cur_pc,
  input logic          user_mode,
  input logic          pm_req,
  input logic          redirect_valid,
  input logic [AW-1:0] redirect_pc,
  input logic [AW-1:0] return_addr,
  input logic [SW-1:0] status,
  input logic [AW-1:0] handler_addr,
  input logic          req_pending
);
  localparam logic [AW-1:0] ALIGN = ~AW'(3);

  assert_stay_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_pending && !user_mode |=> req_pending);
  assert_take_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_pending && user_mode && !pm_req |=> !req_pending);
  assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $past(req_pending && user_mode && status[GE_BIT] && status[PME_BIT]));
  assert_status_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (!status[GE_BIT] && status[OCC_BIT]));
  assert_return_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> return_addr == ($past(cur_pc) & ALIGN));
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);
  assert_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> redirect_pc == $past(handler_addr));
  assert_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    return_addr[1:0] == 2'b00 && handler_addr[1:0] == 2'b00);
endmodule

bind user_event_branch user_event_branch_chk #(
  .AW(AW), .SW(SW), .GE_BIT(GE_BIT), .PME_BIT(PME_BIT), .OCC_BIT(OCC_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .user_mode(user_mode), .pm_req(pm_req),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .return_addr(return_addr),
  .status(status), .handler_addr(handler_addr), .req_pending(req_pending)
);

// File: tb/user_event_branch_tb_top.sv
module user_event_branch_tb_top;
  localparam int AW = 32;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] cur_pc = '0;
  logic user_mode = 1'b0;
  logic pm_req = 1'b0;
  logic sw_we = 1'b0;
  logic [1:0] sw_sel = 2'd0;
  logic [AW-1:0] sw_wdata = '0;
  logic redirect_valid;
  logic [AW-1:0] redirect_pc, return_addr, handler_addr;
  logic [SW-1:0] status;
  logic req_pending;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  user_event_branch #(.AW(AW), .SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .user_mode(user_mode), .pm_req(pm_req),
    .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .return_addr(return_addr),
    .status(status), .handler_addr(handler_addr), .req_pending(req_pending)
  );

  typedef struct packed {
    logic          user;
    logic          ge;
    logic          pme;
    logic [31:0]   pc;
    logic [31:0]   hnd;
    logic          redir;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b1, 32'h1000_0004, 32'h2000_0100, 1'b1},
    '{1'b1, 1'b1, 1'b0, 32'h1000_0008, 32'h2000_0200, 1'b0},
    '{1'b1, 1'b0, 1'b1, 32'h1000_000C, 32'h2000_0300, 1'b0},
    '{1'b0, 1'b1, 1'b1, 32'h1000_0010, 32'h2000_0400, 1'b0},
    '{1'b1, 1'b1, 1'b1, 32'hABCD_0007, 32'h0000_4003, 1'b1},
    '{1'b1, 1'b0, 1'b0, 32'h1000_0014, 32'h2000_0500, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pm_req = 1'b0; sw_we = 1'b0; user_mode = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sw_write(input logic [1:0] sel, input logic [AW-1:0] data);
    sw_we = 1'b1; sw_sel = sel; sw_wdata = data;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  logic [SW-1:0] st;
  logic [AW-1:0] pc_save;

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1", "pending", 64'(req_pending), 64'd0);
    check("R1", "redirect_valid", 64'(redirect_valid), 64'd0);
    check("R1", "redirect_pc", 64'(redirect_pc), 64'd0);
    check("R1", "return_addr", 64'(return_addr), 64'd0);
    check("R1", "status", 64'(status), 64'd0);
    check("R1", "handler", 64'(handler_addr), 64'd0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      st = {1'b1, 5'b0, VECS[i].pme, VECS[i].ge};
      sw_write(2'd0, AW'(st));
      sw_write(2'd1, VECS[i].hnd);
      check("R10", "status write", 64'(status), 64'(st));
      check("R8", "handler align", 64'(handler_addr), 64'(VECS[i].hnd & ~32'h3));
      cur_pc = VECS[i].pc; user_mode = VECS[i].user; pm_req = 1'b1;
      @(negedge clk);
      pm_req = 1'b0;
      check("R2", "latched", 64'(req_pending), 64'd1);
      @(negedge clk);
      check("R7", "redirect pulse", 64'(redirect_valid), 64'(VECS[i].redir));
      check("R7", "redirect_pc", 64'(redirect_pc),
            VECS[i].redir ? 64'(VECS[i].hnd & ~32'h3) : 64'd0);
      check("R6", "return addr", 64'(return_addr),
            VECS[i].redir ? 64'(VECS[i].pc & ~32'h3) : 64'd0);
      check("R5", "status after", 64'(status),
            VECS[i].redir ? 64'((st & ~8'h01) | 8'h04) : 64'(st));
      check(VECS[i].user ? "R3" : "R2", "pending after", 64'(req_pending),
            VECS[i].user ? 64'd0 : 64'd1);
      @(negedge clk);
      check("R7", "pulse ends", 64'(redirect_valid), 64'd0);
      check("R4", "no late redirect status", 64'(status),
            VECS[i].redir ? 64'((st & ~8'h01) | 8'h04) : 64'(st));
    end

    // R2: request held across privileged cycles, then taken
    do_reset();
    sw_write(2'd0, 32'h3);
    sw_write(2'd1, 32'h0000_8000);
    cur_pc = 32'h0000_1230; pm_req = 1'b1;
    @(negedge clk);
    pm_req = 1'b0;
    repeat (5) @(negedge clk);
    check("R2", "still pending", 64'(req_pending), 64'd1);
    check("R2", "no redirect while privileged", 64'(redirect_valid), 64'd0);
    user_mode = 1'b1;
    @(negedge clk);
    check("R2", "taken in user mode", 64'(redirect_valid), 64'd1);
    check("R6", "return addr", 64'(return_addr), 64'h0000_1230);

    // R9: software writes collide with acceptance
    do_reset();
    sw_write(2'd0, 32'h13);
    sw_write(2'd1, 32'h0000_9000);
    user_mode = 1'b1; cur_pc = 32'h0000_4444; pm_req = 1'b1;
    @(negedge clk);
    pm_req = 1'b0;
    sw_write(2'd0, 32'h00);
    check("R9", "status write lost", 64'(status), 64'h16);
    check("R9", "redirect fired", 64'(redirect_valid), 64'd1);
    do_reset();
    sw_write(2'd0, 32'h03);
    user_mode = 1'b1; cur_pc = 32'h0000_5550; pm_req = 1'b1;
    @(negedge clk);
    pm_req = 1'b0;
    sw_write(2'd2, 32'h0000_7770);
    check("R9", "return write lost", 64'(return_addr), 64'h0000_5550);

    // R4: consumed without redirect keeps return register
    do_reset();
    sw_write(2'd2, 32'h0000_6667);
    check("R8", "return align", 64'(return_addr), 64'h0000_6664);
    sw_write(2'd0, 32'h02);
    user_mode = 1'b1; cur_pc = 32'h0000_1110; pm_req = 1'b1;
    @(negedge clk);
    pm_req = 1'b0;
    @(negedge clk);
    check("R4", "consumed no pulse", 64'(redirect_valid), 64'd0);
    check("R4", "return kept", 64'(return_addr), 64'h0000_6664);
    check("R3", "consumed clears pending", 64'(req_pending), 64'd0);
    sw_write(2'd0, 32'h5A);
    check("R10", "write outside accept", 64'(status), 64'h5A);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule